// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

A watchdog peripheral behind one 32-bit configuration register. The low 24 bits hold a reload value, and every write to the register stores them. The timer counts down in units of 256 clock cycles. When the count runs out, the block raises its timeout output, which a parameter sets up as either a held interrupt level or a single-cycle reset pulse.

Turning the timer on or off, and restarting its count, each take two writes. The first write places the key value 1 in a dedicated 2-bit field, and the second places the value 2 in the same field. The on/off field toggles the timer, while the restart field reloads it. A single stray write therefore cannot start, stop or feed the watchdog.

The timer controller has three states: `TMR_OFF`, `TMR_RUN` and `TMR_EXPIRED`. It moves between them as follows:
- **start** (`TMR_OFF`→`TMR_RUN`): the on/off key completes while the timer is off.
- **stop** (`TMR_RUN`/`TMR_EXPIRED`→`TMR_OFF`): the on/off key completes while the timer is on.
- **feed** (`TMR_RUN`→`TMR_RUN` and `TMR_EXPIRED`→`TMR_RUN`): the restart key completes while the timer is on.
- **expire** (`TMR_RUN`→`TMR_EXPIRED`): the count is zero and no key completes.

Each key field has its own sequencer with two states, `KEY_IDLE` and `KEY_ARMED`. It moves between them as follows:
- **arm** (`KEY_IDLE`→`KEY_ARMED`): a write carries 1 in the field.
- **fire** (`KEY_ARMED`→`KEY_IDLE`): a write carries 2 in the field, and the sequence completes.
- **abort** (`KEY_ARMED`→`KEY_IDLE`): a write carries 3 in the field.

Top module: `kwdt_top`

## Requirements
- R1: After reset, rd_data is all zero, tmo_out is low and the timer is off.
- R2: Every write stores wr_data[23:0] as the reload value. From the next cycle on, rd_data[23:0] shows that value.
- R3: rd_data[31] reads 1 while the timer is on (`TMR_RUN` or `TMR_EXPIRED`) and 0 while it is off. rd_data[30:24] always read 0.
- R4: The on/off key field is wr_data[25:24]. A write with 1 there, followed by a write with 2, toggles the timer. A single write alone never changes the on/off state.
- R5: Key rules apply to each field independently. Value 1 arms the field. Value 2 completes the sequence only when the field is armed, and then disarms it. Value 3 disarms the field. Value 0 leaves the armed flag unchanged.
- R6: The restart key field is wr_data[27:26], and it uses the same 1-then-2 sequence. While the timer is on, a completed restart reloads the count from the reload value of the completing write, restarts the 256-cycle prescaler from zero and clears a pending timeout. While the timer is off, a completed restart has no effect.
- R7: Starting the timer loads the count from the reload value of the completing write, with the prescaler at zero. With reload value N, the timer expires 256·N+1 clock edges after that write's edge. N = 0 expires on the next edge.
- R8: In level mode (PULSE_MODE=0), tmo_out is high exactly while the timer is in `TMR_EXPIRED`. It stays high until a completed restart or a stop.
- R9: In pulse mode (PULSE_MODE=1), tmo_out is high for one cycle, in the first cycle of `TMR_EXPIRED`.
- R10: When one write completes both key sequences, the on/off toggle takes effect and the restart is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: [23:0] reload value, [25:24] on/off key, [27:26] restart key |
| rd_data | output | 32 | Read data: [31] timer on, [23:0] stored reload value |
| tmo_out | output | 1 | Timeout: level interrupt or one-cycle reset pulse, chosen by PULSE_MODE |

## Verification
The countdown is tried with reload values 0, 1, 2 and 3. Each expiry is checked on the exact edge where it should occur, which exposes off-by-one errors in the prescaler and the counter. The key fields are driven with orderly sequences, with interrupted sequences (3 between the steps, 2 with no arm) and with 0 between the steps. These patterns separate a sequencer that forgets its armed flag from one that ignores an abort. Writes that complete both fields at once, and restarts issued while the timer is off or part-way through a count, separate the priority rule and the prescaler restart from a naive reload. Both output modes run side by side on the same stimulus against a cycle-by-cycle model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int REG_W      = 32;
    localparam int ONOFF_LSB  = 24;
    localparam int FEED_LSB   = 26;
    localparam int STATUS_BIT = 31;

    localparam logic [1:0] KEY_STEP_ARM  = 2'd1;
    localparam logic [1:0] KEY_STEP_FIRE = 2'd2;
    localparam logic [1:0] KEY_STEP_NONE = 2'd0;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef enum logic [1:0] {
        TMR_OFF     = 2'd0,
        TMR_RUN     = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] key_field,
    output logic       fire,
    output logic       armed
);

    key_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KEY_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: arm, fire, abort
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_IDLE: begin
                if (wr_en && key_field == KEY_STEP_ARM) begin
                    st_d = KEY_ARMED;
                end
            end
            KEY_ARMED: begin
                if (wr_en && key_field != KEY_STEP_NONE && key_field != KEY_STEP_ARM) begin
                    st_d = KEY_IDLE;
                end
            end
            default: st_d = KEY_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed = (st_q == KEY_ARMED);
        fire  = wr_en && (st_q == KEY_ARMED) && (key_field == KEY_STEP_FIRE);
    end

    p_arm_on_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_field == KEY_STEP_ARM) |=> armed);

    p_abort_on_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_field == 2'd3) |=> !armed);

    p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_field == KEY_STEP_NONE) |=> (armed == $past(armed)));

    p_fire_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed);

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int RELOAD_W   = 24,
    parameter int PRESCALE_W = 8,
    parameter bit PULSE_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                onoff_fire,
    input  logic                feed_fire,
    input  logic [RELOAD_W-1:0] load_val,
    output logic                timer_on,
    output logic                timeout
);

    tmr_state_e            st_q, st_d;
    logic                  do_load;
    logic                  do_tick;
    logic [RELOAD_W-1:0]   cnt_q;
    logic [PRESCALE_W-1:0] pre_q;
    logic                  pulse_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TMR_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: start, stop, feed, expire
    always_comb begin
        st_d    = st_q;
        do_load = 1'b0;
        unique case (st_q)
            TMR_OFF: begin
                if (onoff_fire) begin
                    st_d    = TMR_RUN;
                    do_load = 1'b1;
                end
            end
            TMR_RUN: begin
                if (onoff_fire) begin
                    st_d = TMR_OFF;
                end else if (feed_fire) begin
                    do_load = 1'b1;
                end else if (cnt_q == '0) begin
                    st_d = TMR_EXPIRED;
                end
            end
            TMR_EXPIRED: begin
                if (onoff_fire) begin
                    st_d = TMR_OFF;
                end else if (feed_fire) begin
                    st_d    = TMR_RUN;
                    do_load = 1'b1;
                end
            end
            default: st_d = TMR_OFF;
        endcase
    end

    assign do_tick = (st_q == TMR_RUN) && !onoff_fire && !feed_fire && (cnt_q != '0);

    // countdown with prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (do_load) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (do_tick) begin
            pre_q <= pre_q + 1'b1;
            if (pre_q == '1) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (st_q == TMR_RUN) && (st_d == TMR_EXPIRED);
        end
    end

    assign timer_on = (st_q != TMR_OFF);

    generate
        if (PULSE_MODE) begin : g_pulse
            assign timeout = pulse_q;

            p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
                timeout |=> !timeout);
        end else begin : g_level
            assign timeout = (st_q == TMR_EXPIRED);

            p_level_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (timeout && !onoff_fire && !feed_fire) |=> timeout);
        end
    endgenerate

    p_start_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TMR_OFF && onoff_fire) |=> (cnt_q == $past(load_val) && pre_q == '0));

    p_feed_off_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TMR_OFF && feed_fire && !onoff_fire) |=> (st_q == TMR_OFF));

    p_toggle_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TMR_OFF && onoff_fire && feed_fire) |=> (st_q == TMR_OFF));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int RELOAD_W   = 24,
    parameter int PRESCALE_W = 8,
    parameter bit PULSE_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              tmo_out
);

    localparam int ONOFF_MSB = ONOFF_LSB + 1;
    localparam int FEED_MSB  = FEED_LSB + 1;

    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] load_val;
    logic                onoff_fire, feed_fire;
    logic                onoff_armed, feed_armed;
    logic                timer_on;
    logic [3:0]          unused_hi;
    logic                unused_arm;

    assign unused_hi  = wr_data[REG_W-1:FEED_MSB+1];
    assign unused_arm = onoff_armed ^ feed_armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_en) begin
            reload_q <= wr_data[RELOAD_W-1:0];
        end
    end

    assign load_val = wr_data[RELOAD_W-1:0];

    kwdt_key_seq u_onoff_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .key_field (wr_data[ONOFF_MSB:ONOFF_LSB]),
        .fire      (onoff_fire),
        .armed     (onoff_armed)
    );

    kwdt_key_seq u_feed_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .key_field (wr_data[FEED_MSB:FEED_LSB]),
        .fire      (feed_fire),
        .armed     (feed_armed)
    );

    kwdt_core #(
        .RELOAD_W   (RELOAD_W),
        .PRESCALE_W (PRESCALE_W),
        .PULSE_MODE (PULSE_MODE)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .onoff_fire (onoff_fire),
        .feed_fire  (feed_fire),
        .load_val   (load_val),
        .timer_on   (timer_on),
        .timeout    (tmo_out)
    );

    always_comb begin
        rd_data                   = '0;
        rd_data[RELOAD_W-1:0]     = reload_q;
        rd_data[STATUS_BIT]       = timer_on;
    end

    p_reload_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[RELOAD_W-1:0] == $past(wr_data[RELOAD_W-1:0])));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STATUS_BIT-1:ONOFF_LSB] == '0);

endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd_data_p;
    logic        tmo_lvl, tmo_pls;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kwdt_top #(.PULSE_MODE(1'b0)) u_kwdt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tmo_out(tmo_lvl)
    );

    kwdt_top #(.PULSE_MODE(1'b1)) u_kwdt_top_pulse (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data_p), .tmo_out(tmo_pls)
    );

    // behavioural reference model
    int m_st = 0;      // 0 off, 1 counting, 2 expired
    int m_cnt = 0;
    int m_pre = 0;
    int m_reload = 0;
    bit m_arm_e = 0;
    bit m_arm_s = 0;
    bit m_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pre = 0; m_reload = 0;
            m_arm_e = 0; m_arm_s = 0; m_pulse = 0;
        end else begin
            int ef, sf, prev;
            bit fe, fs;
            ef = wr_en ? int'(wr_data[25:24]) : 0;
            sf = wr_en ? int'(wr_data[27:26]) : 0;
            fe = (ef == 2) && m_arm_e;
            fs = (sf == 2) && m_arm_s;
            if (ef == 1) m_arm_e = 1; else if (ef >= 2) m_arm_e = 0;
            if (sf == 1) m_arm_s = 1; else if (sf >= 2) m_arm_s = 0;
            if (wr_en) m_reload = int'(wr_data[23:0]);
            prev = m_st;
            if (fe) begin
                if (m_st == 0) begin
                    m_st = 1; m_cnt = m_reload; m_pre = 0;
                end else begin
                    m_st = 0;
                end
            end else if (fs && m_st != 0) begin
                m_st = 1; m_cnt = m_reload; m_pre = 0;
            end else if (m_st == 1) begin
                if (m_cnt == 0) begin
                    m_st = 2;
                end else begin
                    if (m_pre == 255) m_cnt = m_cnt - 1;
                    m_pre = (m_pre + 1) % 256;
                end
            end
            m_pulse = (prev == 1) && (m_st == 2);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            exp_rd = {(m_st != 0), 7'b0, m_reload[23:0]};
            check(rd_data == exp_rd, "R2/R3", "rd_data vs model", rd_data, exp_rd);
            check(rd_data_p == exp_rd, "R2/R3", "pulse rd_data vs model", rd_data_p, exp_rd);
            check(tmo_lvl == (m_st == 2), "R8", "level timeout vs model", tmo_lvl, (m_st == 2));
            check(tmo_pls == m_pulse, "R9", "pulse timeout vs model", tmo_pls, m_pulse);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic kwrite(input logic [1:0] ef, input logic [1:0] sf, input logic [23:0] rv);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {4'b0, sf, ef, rv};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0, "R1", "rd_data after reset", rd_data, 0);
        check(tmo_lvl == 1'b0 && tmo_pls == 1'b0, "R1", "timeout after reset", tmo_lvl, 0);

        kwrite(2'd0, 2'd0, 24'd5);
        check(rd_data[23:0] == 24'd5, "R2", "reload readback", rd_data[23:0], 5);
        check(rd_data[31] == 1'b0, "R3", "status off", rd_data[31], 0);

        kwrite(2'd1, 2'd0, 24'd2);
        check(rd_data[31] == 1'b0, "R4", "single key step keeps off", rd_data[31], 0);
        kwrite(2'd2, 2'd0, 24'd2);
        check(rd_data[31] == 1'b1, "R4", "key sequence turns on", rd_data[31], 1);

        wait_cyc(512);
        check(tmo_lvl == 1'b0, "R7", "no timeout one edge early", tmo_lvl, 0);
        @(negedge clk);
        check(tmo_lvl == 1'b1, "R7", "timeout at 256*N+1", tmo_lvl, 1);
        check(tmo_pls == 1'b1, "R9", "pulse on expiry", tmo_pls, 1);
        @(negedge clk);
        check(tmo_pls == 1'b0, "R9", "pulse lasts one cycle", tmo_pls, 0);
        wait_cyc(20);
        check(tmo_lvl == 1'b1, "R8", "level held while expired", tmo_lvl, 1);

        kwrite(2'd0, 2'd1, 24'd1);
        kwrite(2'd0, 2'd3, 24'd1);
        kwrite(2'd0, 2'd2, 24'd1);
        check(tmo_lvl == 1'b1, "R5", "value 3 aborts restart key", tmo_lvl, 1);

        kwrite(2'd0, 2'd1, 24'd1);
        kwrite(2'd0, 2'd0, 24'd1);
        kwrite(2'd0, 2'd2, 24'd1);
        check(tmo_lvl == 1'b0, "R6", "restart clears timeout", tmo_lvl, 0);

        kwrite(2'd2, 2'd0, 24'd1);
        check(rd_data[31] == 1'b1, "R5", "fire without arm ignored", rd_data[31], 1);

        kwrite(2'd1, 2'd1, 24'd1);
        kwrite(2'd0, 2'd2, 24'd1);
        kwrite(2'd2, 2'd0, 24'd1);
        check(rd_data[31] == 1'b0, "R5", "independent arms, stop", rd_data[31], 0);
        check(tmo_lvl == 1'b0, "R8", "stop leaves no timeout", tmo_lvl, 0);

        kwrite(2'd0, 2'd1, 24'd1);
        kwrite(2'd0, 2'd2, 24'd1);
        check(rd_data[31] == 1'b0, "R6", "restart while off ignored", rd_data[31], 0);
        wait_cyc(300);
        check(tmo_lvl == 1'b0, "R6", "no timeout while off", tmo_lvl, 0);

        kwrite(2'd1, 2'd1, 24'd0);
        kwrite(2'd2, 2'd2, 24'd0);
        check(rd_data[31] == 1'b1, "R10", "toggle wins over restart", rd_data[31], 1);
        @(negedge clk);
        check(tmo_lvl == 1'b1, "R7", "zero reload expires next edge", tmo_lvl, 1);

        kwrite(2'd1, 2'd1, 24'd0);
        kwrite(2'd2, 2'd2, 24'd0);
        check(rd_data[31] == 1'b0, "R10", "toggle wins while expired", rd_data[31], 0);
        check(tmo_lvl == 1'b0, "R8", "stop clears timeout", tmo_lvl, 0);

        kwrite(2'd1, 2'd0, 24'd3);
        kwrite(2'd2, 2'd0, 24'd3);
        wait_cyc(100);
        kwrite(2'd0, 2'd1, 24'd1);
        kwrite(2'd0, 2'd2, 24'd1);
        wait_cyc(256);
        check(tmo_lvl == 1'b0, "R6", "prescaler restarted by restart", tmo_lvl, 0);
        @(negedge clk);
        check(tmo_lvl == 1'b1, "R6", "expiry 257 edges after restart", tmo_lvl, 1);

        kwrite(2'd1, 2'd0, 24'd0);
        kwrite(2'd2, 2'd0, 24'd0);
        wait_cyc(4);
        check(rd_data[31] == 1'b0 && tmo_lvl == 1'b0, "R4", "final stop", rd_data[31], 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule